// File: doc/BRIEF.md
# Load Data Rotator and Extender

This stage sits directly after the memory read port of a load unit. It turns the raw 32-bit word returned by memory into the value written back to the register file, using the access size, the two low address bits and a signed flag. Misaligned accesses do not fault. A word load from a misaligned address returns the word rotated. A halfword load from an odd address returns the halfword rotated within the 32-bit result. A signed halfword load from an odd address returns a sign-extended byte.

The result is registered once. A valid strobe travels alongside the data with one cycle of latency. When no load is presented, the output register keeps its last value.

Memory data is little-endian: byte lane k sits at bits [8k+7:8k]. The size code is 2'b00 for a byte, 2'b01 for a halfword, 2'b10 for a word, and 2'b11 is handled as a word.

Top module: `load_align_stage`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 32'h0.
- R2: valid_o equals the valid_i value sampled at the previous rising clock edge.
- R3: data_o changes only on an edge where valid_i is high; otherwise it holds its previous value.
- R4: A word load (size 2'b10) with address bits 2'b00 returns raw_i unchanged, whatever the signed flag.
- R5: A word load with address bits a not equal to 0 returns raw_i rotated right by 8*a bits.
- R6: An unsigned halfword load (size 2'b01) from an even address returns the halfword raw_i[16*a[1]+15:16*a[1]], zero-extended.
- R7: A signed halfword load from an even address returns the same halfword, sign-extended from its bit 15.
- R8: An unsigned halfword load from an odd address returns {L, 16'h0, H}, where H and L are the high and low bytes of the halfword raw_i[16*a[1]+15:16*a[1]].
- R9: A signed halfword load from an odd address returns the byte at lane a, sign-extended from its bit 7.
- R10: An unsigned byte load (size 2'b00) returns the byte at lane a, zero-extended.
- R11: A signed byte load returns the byte at lane a, sign-extended.
- R12: Size code 2'b11 gives the same result as a word load (R4, R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A load result is present on the inputs |
| raw_i | input | 32 | Aligned word read from memory |
| addr_lo_i | input | 2 | Low address bits of the load |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 word |
| signed_i | input | 1 | Sign-extend sub-word results |
| valid_o | output | 1 | data_o carries a new result |
| data_o | output | 32 | Aligned, extended write-back value |

## Verification
A wrong rotate amount or a wrong lane select shows up as a byte permutation in data_o on the cycle after the load. For this reason the raw pattern uses four distinct bytes, so each lane can be identified at the output. A fault in the extension logic shows up in the upper bits on that same cycle, and both sign polarities are driven to expose it. A register that loads when no load is presented shows up as data_o changing during idle cycles. A fault in the valid pipeline shows up as valid_o out of step with valid_i by one cycle.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic [1:0] {
    LA_BYTE = 2'b00,
    LA_HALF = 2'b01,
    LA_WORD = 2'b10,
    LA_WIDE = 2'b11
  } la_size_e;
endpackage

// File: rtl/la_rotator.sv
module la_rotator #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W,
  localparam int SEL_W  = $clog2(NLANES)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] rot_o
);
  logic [DATA_W-1:0] cand [NLANES];

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    if (k == 0) begin : g_id
      assign cand[k] = data_i;
    end else begin : g_rot
      assign cand[k] = {data_i[k*LANE_W-1:0], data_i[DATA_W-1:k*LANE_W]};
    end
  end

  assign rot_o = cand[sel_i];
endmodule

// File: rtl/la_extender.sv
module la_extender
  import la_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int HALF_W = 2 * LANE_W
) (
  input  logic [DATA_W-1:0] rot_i,
  input  la_size_e          size_i,
  input  logic              sgn_i,
  input  logic              odd_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] byte_z, byte_s, half_z, half_s, half_rot;

  assign byte_z   = {{(DATA_W-LANE_W){1'b0}}, rot_i[LANE_W-1:0]};
  assign byte_s   = {{(DATA_W-LANE_W){rot_i[LANE_W-1]}}, rot_i[LANE_W-1:0]};
  assign half_z   = {{(DATA_W-HALF_W){1'b0}}, rot_i[HALF_W-1:0]};
  assign half_s   = {{(DATA_W-HALF_W){rot_i[HALF_W-1]}}, rot_i[HALF_W-1:0]};
  // odd halfword: lanes a-1 and a, rotated within the word
  assign half_rot = {rot_i[DATA_W-1 -: LANE_W], {(DATA_W-HALF_W){1'b0}},
                     rot_i[LANE_W-1:0]};

  always_comb begin
    unique case (size_i)
      LA_BYTE: res_o = sgn_i ? byte_s : byte_z;
      LA_HALF: begin
        if (odd_i) res_o = sgn_i ? byte_s : half_rot;
        else       res_o = sgn_i ? half_s : half_z;
      end
      default: res_o = rot_i;
    endcase
  end
endmodule

// File: rtl/la_stage_reg.sv
module la_stage_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/load_align_stage.sv
module load_align_stage
  import la_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W,
  localparam int SEL_W  = $clog2(NLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [SEL_W-1:0]  addr_lo_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rot, res;

  la_rotator #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rot (
    .data_i(raw_i),
    .sel_i (addr_lo_i),
    .rot_o (rot)
  );

  la_extender #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ext (
    .rot_i (rot),
    .size_i(la_size_e'(size_i)),
    .sgn_i (signed_i),
    .odd_i (addr_lo_i[0]),
    .res_o (res)
  );

  la_stage_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (res),
    .valid_o(valid_o),
    .data_o (data_o)
  );
endmodule

// File: rtl/la_checker.sv
module la_checker #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int SEL_W = $clog2(DATA_W / LANE_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] raw_i,
  input logic [SEL_W-1:0]  addr_lo_i,
  input logic [1:0]        size_i,
  input logic              signed_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> valid_o == $past(valid_i));

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !$past(valid_i)) |-> $stable(data_o));

  a_r4_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(valid_i) && $past(size_i) == 2'b10 && $past(addr_lo_i) == '0)
      |-> data_o == $past(raw_i));

  a_r10_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(valid_i) && $past(size_i) == 2'b00 && !$past(signed_i))
      |-> data_o[DATA_W-1:LANE_W] == '0);

  a_r11_byte_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(valid_i) && $past(size_i) == 2'b00 && $past(signed_i))
      |-> data_o[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){data_o[LANE_W-1]}});

  a_r7_half_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(valid_i) && $past(size_i) == 2'b01 && $past(signed_i)
     && !$past(addr_lo_i[0]))
      |-> data_o[DATA_W-1:2*LANE_W] == {(DATA_W-2*LANE_W){data_o[2*LANE_W-1]}});
endmodule

bind load_align_stage la_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_la_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .raw_i    (raw_i),
  .addr_lo_i(addr_lo_i),
  .size_i   (size_i),
  .signed_i (signed_i),
  .valid_o  (valid_o),
  .data_o   (data_o)
);

// File: tb/test_load_align_stage.sv
module test_load_align_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] raw_i;
  logic [1:0]  addr_lo_i;
  logic [1:0]  size_i;
  logic        signed_i;
  logic        valid_o;
  logic [31:0] data_o;

  int errors = 0;
  int checks = 0;

  localparam logic [31:0] PAT = 32'h8A7B_C6D5;

  always #10 clk_i = ~clk_i;

  load_align_stage i_load_align_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .raw_i(raw_i),
    .addr_lo_i(addr_lo_i), .size_i(size_i), .signed_i(signed_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one load, result checked one clock later
  task automatic do_load(input string tag, input logic [31:0] raw, input logic [1:0] a,
                         input logic [1:0] sz, input logic sg, input logic [31:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; raw_i = raw; addr_lo_i = a; size_i = sz; signed_i = sg;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " valid"}, {31'b0, valid_o}, 32'd1);
    check(tag, data_o, exp);
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, valid_o}, 32'd0);
    check("R1 data", data_o, 32'h0);
  endtask

  task automatic t_word;
    do_load("R4 a0",        PAT, 2'd0, 2'b10, 1'b0, 32'h8A7B_C6D5);
    do_load("R4 a0 signed", PAT, 2'd0, 2'b10, 1'b1, 32'h8A7B_C6D5);
    do_load("R5 a1",        PAT, 2'd1, 2'b10, 1'b0, 32'hD58A_7BC6);
    do_load("R5 a2 signed", PAT, 2'd2, 2'b10, 1'b1, 32'hC6D5_8A7B);
    do_load("R5 a3",        PAT, 2'd3, 2'b10, 1'b0, 32'h7BC6_D58A);
  endtask

  task automatic t_half;
    do_load("R6 a0",  PAT, 2'd0, 2'b01, 1'b0, 32'h0000_C6D5);
    do_load("R6 a2",  PAT, 2'd2, 2'b01, 1'b0, 32'h0000_8A7B);
    do_load("R7 a0",  PAT, 2'd0, 2'b01, 1'b1, 32'hFFFF_C6D5);
    do_load("R7 pos", 32'h1234_5678, 2'd2, 2'b01, 1'b1, 32'h0000_1234);
    do_load("R8 a1",  PAT, 2'd1, 2'b01, 1'b0, 32'hD500_00C6);
    do_load("R8 a3",  PAT, 2'd3, 2'b01, 1'b0, 32'h7B00_008A);
    do_load("R9 a1",  PAT, 2'd1, 2'b01, 1'b1, 32'hFFFF_FFC6);
    do_load("R9 a3",  PAT, 2'd3, 2'b01, 1'b1, 32'hFFFF_FF8A);
    do_load("R9 pos", 32'h1234_5678, 2'd1, 2'b01, 1'b1, 32'h0000_0056);
  endtask

  task automatic t_byte;
    do_load("R10 a0",  PAT, 2'd0, 2'b00, 1'b0, 32'h0000_00D5);
    do_load("R10 a3",  PAT, 2'd3, 2'b00, 1'b0, 32'h0000_008A);
    do_load("R11 a0",  PAT, 2'd0, 2'b00, 1'b1, 32'hFFFF_FFD5);
    do_load("R11 a1",  PAT, 2'd1, 2'b00, 1'b1, 32'hFFFF_FFC6);
    do_load("R11 pos", PAT, 2'd2, 2'b00, 1'b1, 32'h0000_007B);
  endtask

  task automatic t_wide;
    do_load("R12 a1", PAT, 2'd1, 2'b11, 1'b0, 32'hD58A_7BC6);
    do_load("R12 a0", PAT, 2'd0, 2'b11, 1'b1, 32'h8A7B_C6D5);
  endtask

  task automatic t_hold;
    do_load("R3 setup", 32'h0102_0304, 2'd0, 2'b10, 1'b0, 32'h0102_0304);
    @(negedge clk_i);
    raw_i = 32'hDEAD_BEEF; size_i = 2'b10; addr_lo_i = 2'd0;
    @(negedge clk_i);
    check("R2 idle valid", {31'b0, valid_o}, 32'd0);
    check("R3 hold", data_o, 32'h0102_0304);
    @(negedge clk_i);
    check("R3 hold 2", data_o, 32'h0102_0304);
    valid_i = 1'b1; raw_i = PAT; size_i = 2'b00; addr_lo_i = 2'd1; signed_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 rise", {31'b0, valid_o}, 32'd1);
    check("R10 after idle", data_o, 32'h0000_00C6);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b1; raw_i = PAT; addr_lo_i = 2'd0;
    size_i = 2'b10; signed_i = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_word();
    t_half();
    t_byte();
    t_wide();
    t_hold();
    report();
  end

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end
endmodule